// File: doc/BRIEF.md
# Event Timestamp Record Buffer

This block keeps timestamp records of detected events and a running count of how many events have occurred. It has four record slots. Slot 0 captures the first event after reset or clear and holds it from then on. Slots 1 to 3 form a sliding window of the three most recent events, and slot 3 always holds the newest one. An 8-bit saturating counter tallies every event, however many records are kept.

A 2-bit index selects which slot a read returns. A read strobe loads the selected slot into a registered read port on the next clock edge. A clear input empties the records and zeroes the counter, so the next event becomes the new first record. The block does not generate timestamps and has no serial bus and no non-volatile storage.

Top module: `evt_stamp_buf`

## Requirements
- R1: After reset or clear, the first event writes its timestamp into slot 0. No later event changes slot 0 until the next clear.
- R2: Each event after slot 0 is filled shifts the window: slot 1 takes slot 2, slot 2 takes slot 3, and slot 3 takes the new timestamp.
- R3: A slot that no event has filled reads as zero.
- R4: Each event strobe that comes without a clear raises `evt_count_o` by one on the next clock.
- R5: `evt_count_o` saturates at 255 and never wraps.
- R6: A clear zeroes all slots and the counter and frees slot 0. Clear takes priority over an event in the same cycle. Clear does not change the index.
- R7: An index write loads bits 1:0 of `idx_wdata_i` into `idx_o`; bits 7:2 are ignored. The index encodes slot numbers: 0 is the first record, 3 is the latest. Without a write the index holds.
- R8: When `rd_en_i` is high at a clock edge, `rd_ts_o` loads the slot selected by the index value held before that edge. Otherwise `rd_ts_o` holds.
- R9: A read in the same cycle as an event returns the slot contents from before the event. The update can be seen by a read in the next cycle.
- R10: Reset zeroes the slots, the counter, the index and `rd_ts_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Event strobe, one event per cycle it is high |
| ts_i | input | TS_W | Timestamp to record with the event |
| clr_i | input | 1 | Clears the records and the counter |
| idx_we_i | input | 1 | Index write strobe |
| idx_wdata_i | input | 8 | Index write data; only bits 1:0 are used |
| rd_en_i | input | 1 | Read strobe |
| rd_ts_o | output | TS_W | Registered read data |
| evt_count_o | output | CNT_W | Saturating event count |
| idx_o | output | 2 | Current slot index |

## Verification
The bench targets the second and third events after a clear. A design that shifts the whole array, slot 0 included, loses the pinned first record. A design that fills slots from the bottom up puts the second event somewhere other than slot 3. The bench drives more than 255 events to catch a counter that wraps to zero. It also drives a clear and an event in the same cycle to catch a design that lets the event win. Same-cycle reads and events expose a read port that returns post-event data. An index write with its upper bits set catches index logic that is too wide.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
    localparam int NUM_SLOTS = 4;
    localparam int IDX_W     = $clog2(NUM_SLOTS);
    localparam int IDX_WR_W  = 8;

    typedef enum logic [IDX_W-1:0] {
        SLOT_FIRST  = 2'd0,
        SLOT_OLDEST = 2'd1,
        SLOT_MIDDLE = 2'd2,
        SLOT_LATEST = 2'd3
    } slot_e;

    typedef struct packed {
        logic evt;
        logic clr;
    } evt_ctl_t;

    function automatic logic take_event(evt_ctl_t c);
        return c.evt && !c.clr;
    endfunction
endpackage

// File: rtl/evt_slot_store.sv
module evt_slot_store
    import evt_stamp_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  evt_ctl_t                        ctl,
    input  logic [TS_W-1:0]                 ts,
    output logic [NUM_SLOTS-1:0][TS_W-1:0]  slots_o
);
    logic [NUM_SLOTS-1:0][TS_W-1:0] slot_q;
    logic                           first_taken_q;

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            first_taken_q      <= 1'b0;
            slot_q[SLOT_FIRST] <= '0;
        end else if (take_event(ctl) && !first_taken_q) begin
            first_taken_q      <= 1'b1;
            slot_q[SLOT_FIRST] <= ts;
        end
    end

    for (genvar g = 1; g < NUM_SLOTS; g++) begin : g_window
        logic [TS_W-1:0] next_val;
        if (g == NUM_SLOTS - 1) begin : g_top
            assign next_val = ts;
        end else begin : g_mid
            assign next_val = slot_q[g+1];
        end
        always_ff @(posedge clk) begin
            if (rst || ctl.clr) begin
                slot_q[g] <= '0;
            end else if (take_event(ctl) && first_taken_q) begin
                slot_q[g] <= next_val;
            end
        end
    end

    assign slots_o = slot_q;
endmodule

// File: rtl/evt_counter.sv
module evt_counter
    import evt_stamp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  evt_ctl_t         ctl,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            cnt_q <= '0;
        end else if (take_event(ctl) && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/evt_index_reg.sv
module evt_index_reg
    import evt_stamp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [IDX_WR_W-1:0] wdata,
    output logic [IDX_W-1:0]    idx_o
);
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (we) begin
            idx_q <= wdata[IDX_W-1:0];
        end
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/evt_stamp_buf.sv
module evt_stamp_buf
    import evt_stamp_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                evt_i,
    input  logic [TS_W-1:0]     ts_i,
    input  logic                clr_i,
    input  logic                idx_we_i,
    input  logic [IDX_WR_W-1:0] idx_wdata_i,
    input  logic                rd_en_i,
    output logic [TS_W-1:0]     rd_ts_o,
    output logic [CNT_W-1:0]    evt_count_o,
    output logic [IDX_W-1:0]    idx_o
);
    evt_ctl_t                       ctl;
    logic [NUM_SLOTS-1:0][TS_W-1:0] slots;
    logic [TS_W-1:0]                rd_q;

    assign ctl.evt = evt_i;
    assign ctl.clr = clr_i;

    evt_slot_store #(.TS_W(TS_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .ts      (ts_i),
        .slots_o (slots)
    );

    evt_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .count_o (evt_count_o)
    );

    evt_index_reg u_index (
        .clk   (clk),
        .rst   (rst),
        .we    (idx_we_i),
        .wdata (idx_wdata_i),
        .idx_o (idx_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en_i) begin
            rd_q <= slots[idx_o];
        end
    end

    assign rd_ts_o = rd_q;
endmodule

// File: rtl/evt_stamp_buf_chk.sv
module evt_stamp_buf_chk
    import evt_stamp_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int CNT_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                evt_i,
    input logic                clr_i,
    input logic                idx_we_i,
    input logic [IDX_WR_W-1:0] idx_wdata_i,
    input logic                rd_en_i,
    input logic [TS_W-1:0]     rd_ts_o,
    input logic [CNT_W-1:0]    evt_count_o,
    input logic [IDX_W-1:0]    idx_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (evt_i && !clr_i && evt_count_o != CMAX) |=> evt_count_o == $past(evt_count_o) + 1'b1);

    a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (evt_count_o == CMAX && !clr_i) |=> evt_count_o == CMAX);

    a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> evt_count_o == '0);

    a_r7_idx_load: assert property (@(posedge clk) disable iff (rst)
        idx_we_i |=> idx_o == $past(idx_wdata_i[IDX_W-1:0]));

    a_r7_idx_hold: assert property (@(posedge clk) disable iff (rst)
        !idx_we_i |=> $stable(idx_o));

    a_r8_rd_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> $stable(rd_ts_o));
endmodule

bind evt_stamp_buf evt_stamp_buf_chk #(.TS_W(TS_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt_i),
    .clr_i       (clr_i),
    .idx_we_i    (idx_we_i),
    .idx_wdata_i (idx_wdata_i),
    .rd_en_i     (rd_en_i),
    .rd_ts_o     (rd_ts_o),
    .evt_count_o (evt_count_o),
    .idx_o       (idx_o)
);

// File: tb/evt_stamp_buf_tb.sv
module evt_stamp_buf_tb;
    localparam int TS_W = 32;
    localparam int CNT_W = 8;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             evt_i = 1'b0;
    logic [TS_W-1:0]  ts_i = '0;
    logic             clr_i = 1'b0;
    logic             idx_we_i = 1'b0;
    logic [7:0]       idx_wdata_i = '0;
    logic             rd_en_i = 1'b0;
    logic [TS_W-1:0]  rd_ts_o;
    logic [CNT_W-1:0] evt_count_o;
    logic [1:0]       idx_o;

    int errors = 0;
    int checks = 0;

    logic [TS_W-1:0] m_slot [4];
    logic            m_first;
    int              m_cnt;
    logic [1:0]      m_idx;

    logic [TS_W-1:0] exp_q [$];
    string           tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_stamp_buf #(.TS_W(TS_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .ts_i(ts_i), .clr_i(clr_i),
        .idx_we_i(idx_we_i), .idx_wdata_i(idx_wdata_i), .rd_en_i(rd_en_i),
        .rd_ts_o(rd_ts_o), .evt_count_o(evt_count_o), .idx_o(idx_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4; i++) m_slot[i] = '0;
        m_first = 1'b0;
        m_cnt = 0;
    endtask

    // Driver: drives one cycle, pushes the expected read result, updates the model.
    task automatic step(input logic e, input logic [TS_W-1:0] t, input logic c,
                        input logic iw, input logic [7:0] iv, input logic r, input string tag);
        @(negedge clk);
        evt_i = e; ts_i = t; clr_i = c; idx_we_i = iw; idx_wdata_i = iv; rd_en_i = r;
        if (r) begin
            exp_q.push_back(m_slot[m_idx]);
            tag_q.push_back(tag);
        end
        if (c) model_clear();
        else if (e) begin
            if (!m_first) begin
                m_slot[0] = t;
                m_first = 1'b1;
            end else begin
                m_slot[1] = m_slot[2];
                m_slot[2] = m_slot[3];
                m_slot[3] = t;
            end
            if (m_cnt < 255) m_cnt++;
        end
        if (iw) m_idx = iv[1:0];
        @(posedge clk);
        #2;
        evt_i = 0; clr_i = 0; idx_we_i = 0; rd_en_i = 0;
    endtask

    task automatic read_slot(input logic [1:0] s, input string tag);
        step(0, '0, 0, 1, {6'b0, s}, 0, tag);
        step(0, '0, 0, 0, 8'h00, 1, tag);
    endtask

    // Monitor: pops and compares expected read data one step after a read edge.
    initial begin
        forever begin
            logic took;
            @(posedge clk);
            took = (rd_en_i === 1'b1) && !rst;
            #1;
            if (took) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R8 actual=%0h expected=<no read queued>", rd_ts_o);
                end else begin
                    logic [TS_W-1:0] ev;
                    string tg;
                    ev = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    check(tg, rd_ts_o, ev);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_clear();
        m_idx = 0;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R10: reset state
        check("R10 count", evt_count_o, 0);
        check("R10 idx", idx_o, 0);
        check("R10 rd", rd_ts_o, 0);
        // R3: empty slots read zero
        for (int s = 0; s < 4; s++) read_slot(s[1:0], "R3 empty");
        // R9: read slot 0 in the same cycle as the first event
        step(0, '0, 0, 1, 8'h00, 0, "R7");
        step(1, 32'hA1, 0, 0, 8'h00, 1, "R9 pre-event");
        step(0, '0, 0, 0, 8'h00, 1, "R1 first");
        check("R4 count1", evt_count_o, 1);
        // R2: second event goes to slot 3, slots 1 and 2 still zero (R3)
        step(1, 32'hA2, 0, 0, 8'h00, 0, "R2");
        read_slot(3, "R2 latest");
        read_slot(2, "R3 unfilled");
        read_slot(1, "R3 unfilled");
        step(1, 32'hA3, 0, 0, 8'h00, 0, "R2");
        step(1, 32'hA4, 0, 0, 8'h00, 0, "R2");
        step(1, 32'hA5, 0, 0, 8'h00, 0, "R2");
        for (int s = 0; s < 4; s++) read_slot(s[1:0], "R1/R2 window");
        check("R4 count5", evt_count_o, 5);
        // R9: event and read of slot 3 together, then next cycle
        step(0, '0, 0, 1, 8'h03, 0, "R7");
        step(1, 32'hA6, 0, 0, 8'h00, 1, "R9 pre-event");
        step(0, '0, 0, 0, 8'h00, 1, "R9 post");
        // R8: read uses the old index when written in same cycle, then holds
        step(0, '0, 0, 1, 8'h00, 1, "R8 old idx");
        step(0, '0, 0, 0, 8'h00, 0, "R8");
        check("R8 hold", rd_ts_o, 32'hA6);
        // R7: upper bits ignored
        step(0, '0, 0, 1, 8'hFE, 0, "R7");
        check("R7 low bits", idx_o, 2);
        step(0, '0, 0, 0, 8'hFF, 0, "R7");
        check("R7 no write", idx_o, 2);
        // R6: clear with event in same cycle, index kept
        step(1, 32'hB0, 1, 0, 8'h00, 0, "R6");
        check("R6 count", evt_count_o, 0);
        check("R6 idx kept", idx_o, 2);
        for (int s = 0; s < 4; s++) read_slot(s[1:0], "R6 cleared");
        // R1: new first record after clear
        step(1, 32'hC1, 0, 0, 8'h00, 0, "R1");
        step(1, 32'hC2, 0, 0, 8'h00, 0, "R1");
        read_slot(0, "R1 refill");
        // R5: saturation
        for (int i = 0; i < 260; i++) step(1, 32'hD000 + i, 0, 0, 8'h00, 0, "R5");
        check("R5 saturate", evt_count_o, 255);
        read_slot(0, "R1 pinned");
        read_slot(3, "R2 latest");
        step(1, 32'hE0, 0, 0, 8'h00, 0, "R5");
        check("R5 stays", evt_count_o, 255);
        check("R5 model", evt_count_o, m_cnt);
        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R8 actual=%0d pending expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule